// File: doc/BRIEF.md
# YCbCr to RGB555 Colour Converter

This block turns a pixel stream of 8-bit luma (Y) and offset-binary colour-difference samples (Cb, Cr) into 15-bit RGB pixels with 5 bits per colour. It sits between a video decoder's digital output and a frame store or pixel processor. Horizontal and vertical sync flags enter with each sample and leave with the pixel built from it, so downstream logic can rebuild line and frame position.

The conversion uses fixed-point constants scaled by 1024: red adds 1404·Cr' to Y, blue adds 1774·Cb', and green subtracts 344·Cb' and 715·Cr'. Here Cb' = Cb − 128 and Cr' = Cr − 128. Each sum is rounded by adding 512, shifted right arithmetically by 10 (rounding toward minus infinity), clamped to 0..255, and bits [7:3] of the clamped value become the 5-bit component. The work takes three register stages.

Both stream edges use valid/ready. A beat transfers on a rising clock edge where valid and ready are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_valid` low or `out_ready` high). When it is high, the whole pipeline moves one step. When it is low, nothing moves: the output beat holds, and no input beat is taken. An idle slot (valid low) travels through the pipeline as a bubble. Sync flags are sampled together with the data of the beat that carries them.

Top module: `ycc2rgb555`

## Requirements
- R1: For an accepted sample, out_r equals bits [7:3] of clamp(floor((1024·Y + 1404·(Cr−128) + 512) / 1024)).
- R2: out_g equals bits [7:3] of clamp(floor((1024·Y − 344·(Cb−128) − 715·(Cr−128) + 512) / 1024)).
- R3: out_b equals bits [7:3] of clamp(floor((1024·Y + 1774·(Cb−128) + 512) / 1024)).
- R4: With Cb = Cr = 128 all three components equal Y[7:3] (the chroma offset is removed before multiplying).
- R5: A result above 255 saturates to component value 31, with no wrap-around.
- R6: A result below 0 saturates to component value 0, with no wrap-around.
- R7: With out_ready held high, a sample accepted in cycle n is presented with out_valid high in cycle n+3.
- R8: out_hsync and out_vsync show the flags that entered with the same sample as the pixel on the outputs.
- R9: While out_valid is high and out_ready is low, in_ready is low and out_valid, the components and the syncs all hold their values on the next cycle.
- R10: During and right after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_y | input | 8 | Luma, unsigned |
| in_cb | input | 8 | Blue colour difference, offset by 128 |
| in_cr | input | 8 | Red colour difference, offset by 128 |
| in_hsync | input | 1 | Horizontal sync flag for this sample |
| in_vsync | input | 1 | Vertical sync flag for this sample |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the pixel this cycle |
| out_r | output | 5 | Red component |
| out_g | output | 5 | Green component |
| out_b | output | 5 | Blue component |
| out_hsync | output | 1 | Horizontal sync aligned to the pixel |
| out_vsync | output | 1 | Vertical sync aligned to the pixel |

## Verification
The bench drives the extreme corners of the colour cube. If saturation were missing, a high red or blue sum would wrap to a small value, or a negative green would wrap to near full scale. It also drives neutral grey at several luma levels: if the 128 offset were not removed, grey would show a strong colour cast. Flags vary between samples while out_ready drops at irregular points. A design that let a sync slip by one stage, dropped a beat, duplicated a beat, or changed the output during a stall would then fail the in-order compare against the independent arithmetic model. An isolated-sample phase pins the three-cycle delay.

// File: rtl/ycc2rgb_pkg.sv
package ycc2rgb_pkg;
  // Fractional bits of the fixed-point constants
  localparam int FRAC_BITS = 10;
  // Colour-difference weights, each scaled by 2**FRAC_BITS
  localparam int K_R_CR = 1404;
  localparam int K_G_CB = 344;
  localparam int K_G_CR = 715;
  localparam int K_B_CB = 1774;
  // Width that holds any of the weights as a signed value
  localparam int K_WIDTH = 12;
  // Components in one pixel: 0 red, 1 green, 2 blue
  localparam int N_COMP = 3;
endpackage

// File: rtl/rgb555_prod_stage.sv
// Stage 1: remove the chroma offset and form the weighted chroma terms.
module rgb555_prod_stage
  import ycc2rgb_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = DW + K_WIDTH + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [DW-1:0]        y,
  input  logic [DW-1:0]        cb,
  input  logic [DW-1:0]        cr,
  output logic [DW-1:0]        y_q,
  output logic signed [PW-1:0] prod_q [N_COMP]
);
  localparam logic signed [DW:0] OFS = {2'b01, {(DW-1){1'b0}}};
  localparam logic signed [PW-1:0] KRCR = PW'(K_R_CR);
  localparam logic signed [PW-1:0] KGCB = PW'(K_G_CB);
  localparam logic signed [PW-1:0] KGCR = PW'(K_G_CR);
  localparam logic signed [PW-1:0] KBCB = PW'(K_B_CB);

  logic signed [DW:0]   cb_s, cr_s;
  logic signed [PW-1:0] cb_w, cr_w;
  logic signed [PW-1:0] prod_d [N_COMP];

  assign cb_s = $signed({1'b0, cb}) - OFS;
  assign cr_s = $signed({1'b0, cr}) - OFS;
  assign cb_w = PW'(cb_s);
  assign cr_w = PW'(cr_s);

  assign prod_d[0] = cr_w * KRCR;
  assign prod_d[1] = -(cb_w * KGCB) - (cr_w * KGCR);
  assign prod_d[2] = cb_w * KBCB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_q <= '0;
      for (int i = 0; i < N_COMP; i++) prod_q[i] <= '0;
    end else if (en) begin
      y_q <= y;
      for (int i = 0; i < N_COMP; i++) prod_q[i] <= prod_d[i];
    end
  end

  AST_GREY_NO_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cb == OFS[DW-1:0] && cr == OFS[DW-1:0]) |=>
      (prod_q[0] == 0 && prod_q[1] == 0 && prod_q[2] == 0)); // R4
endmodule

// File: rtl/rgb555_round_stage.sv
// Stage 2: add the luma, round, and scale back to integer units.
module rgb555_round_stage
  import ycc2rgb_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = DW + K_WIDTH + 2,
  parameter int SW = PW + 1 - FRAC_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [DW-1:0]        y,
  input  logic signed [PW-1:0] prod [N_COMP],
  output logic signed [SW-1:0] sum_q [N_COMP]
);
  localparam int FW = PW + 1;
  localparam logic signed [FW-1:0] RND = FW'(1) <<< (FRAC_BITS - 1);

  logic signed [FW-1:0] y_base;
  assign y_base = FW'($signed({1'b0, y})) <<< FRAC_BITS;

  for (genvar c = 0; c < N_COMP; c++) begin : g_comp
    logic signed [FW-1:0] full;
    assign full = y_base + FW'(prod[c]) + RND;
    always_ff @(posedge clk) begin
      if (!rst_n)  sum_q[c] <= '0;
      else if (en) sum_q[c] <= SW'(full >>> FRAC_BITS);
    end
  end
endmodule

// File: rtl/rgb555_clamp_stage.sv
// Stage 3: saturate to the unsigned range and keep the top output bits.
module rgb555_clamp_stage
  import ycc2rgb_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 13,
  parameter int OW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [SW-1:0] sum [N_COMP],
  output logic [OW-1:0]        comp_q [N_COMP]
);
  localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

  for (genvar c = 0; c < N_COMP; c++) begin : g_comp
    logic [OW-1:0] sat;
    always_comb begin
      if (sum[c] < 0)          sat = '0;
      else if (sum[c] > MAXV)  sat = '1;
      else                     sat = sum[c][DW-1 -: OW];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)  comp_q[c] <= '0;
      else if (en) comp_q[c] <= sat;
    end

    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sum[c] > MAXV) |=> (comp_q[c] == '1)); // R5
    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sum[c] < 0) |=> (comp_q[c] == '0)); // R6
  end
endmodule

// File: rtl/ycc2rgb555.sv
module ycc2rgb555
  import ycc2rgb_pkg::*;
#(
  parameter int DW = 8,
  parameter int OW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_cb,
  input  logic [DW-1:0] in_cr,
  input  logic          in_hsync,
  input  logic          in_vsync,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_r,
  output logic [OW-1:0] out_g,
  output logic [OW-1:0] out_b,
  output logic          out_hsync,
  output logic          out_vsync
);
  localparam int DEPTH = 3;
  localparam int PW = DW + K_WIDTH + 2;
  localparam int SW = PW + 1 - FRAC_BITS;

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Side-band shift registers: valid, hsync, vsync travel with the data
  logic [DEPTH-1:0] v_q, hs_q, vs_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0; hs_q[0] <= 1'b0; vs_q[0] <= 1'b0;
    end else if (adv) begin
      v_q[0] <= in_valid; hs_q[0] <= in_hsync; vs_q[0] <= in_vsync;
    end
  end
  for (genvar k = 1; k < DEPTH; k++) begin : g_side
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[k] <= 1'b0; hs_q[k] <= 1'b0; vs_q[k] <= 1'b0;
      end else if (adv) begin
        v_q[k] <= v_q[k-1]; hs_q[k] <= hs_q[k-1]; vs_q[k] <= vs_q[k-1];
      end
    end
  end

  logic [DW-1:0]        y1;
  logic signed [PW-1:0] prod1 [N_COMP];
  logic signed [SW-1:0] sum2  [N_COMP];
  logic [OW-1:0]        comp3 [N_COMP];

  rgb555_prod_stage #(.DW(DW), .PW(PW)) u_prod (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .y(in_y), .cb(in_cb), .cr(in_cr),
    .y_q(y1), .prod_q(prod1)
  );

  rgb555_round_stage #(.DW(DW), .PW(PW), .SW(SW)) u_round (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .y(y1), .prod(prod1), .sum_q(sum2)
  );

  rgb555_clamp_stage #(.DW(DW), .SW(SW), .OW(OW)) u_clamp (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .sum(sum2), .comp_q(comp3)
  );

  assign out_valid = v_q[DEPTH-1];
  assign out_hsync = hs_q[DEPTH-1];
  assign out_vsync = vs_q[DEPTH-1];
  assign out_r     = comp3[0];
  assign out_g     = comp3[1];
  assign out_b     = comp3[2];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)
       && $stable(out_hsync) && $stable(out_vsync))); // R9
endmodule

// File: tb/ycc2rgb555_bench.sv
module ycc2rgb555_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic       in_hsync = 1'b0, in_vsync = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [4:0] out_r, out_g, out_b;
  logic       out_hsync, out_vsync;

  always #4 clk = ~clk; // 125 MHz

  ycc2rgb555 u_ycc2rgb555 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .in_hsync(in_hsync), .in_vsync(in_vsync),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .out_hsync(out_hsync), .out_vsync(out_vsync)
  );

  typedef struct {
    logic [4:0] r, g, b;
    logic       hs, vs;
    int         cyc;
    string      tag;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0, fails = 0;
  int    cyc = 0;
  bit    lat_mode = 1'b1;
  bit    bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [4:0] sat5(int v);
    if (v < 0)   return 5'd0;
    if (v > 255) return 5'd31;
    return v[7:3];
  endfunction

  function automatic exp_t model(int y, int cb, int cr, logic hs, logic vs);
    exp_t e;
    int cbo, cro;
    cbo  = cb - 128;
    cro  = cr - 128;
    e.r  = sat5((y * 1024 + 1404 * cro + 512) >>> 10);
    e.g  = sat5((y * 1024 - 344 * cbo - 715 * cro + 512) >>> 10);
    e.b  = sat5((y * 1024 + 1774 * cbo + 512) >>> 10);
    e.hs = hs;
    e.vs = vs;
    return e;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Driver: present one sample, wait for acceptance, push expectation
  task automatic send(int y, int cb, int cr, logic hs, logic vs, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
    in_hsync = hs; in_vsync = vs;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e = model(y, cb, cr, hs, vs);
    e.cyc = cyc;
    e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Back-pressure source
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // Monitor: compare each transferred pixel in order; watch stalls
  bit         prev_stall = 1'b0;
  logic [16:0] prev_bus;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || {out_r, out_g, out_b, out_hsync, out_vsync} != prev_bus) begin
          fails++;
          $display("FAIL R9 hold: got valid=%0b bus=%h expected valid=1 bus=%h",
                   out_valid, {out_r, out_g, out_b, out_hsync, out_vsync}, prev_bus);
        end
      end
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready) begin
          fails++;
          $display("FAIL R9 in_ready during stall: got 1 expected 0");
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_bus   = {out_r, out_g, out_b, out_hsync, out_vsync};
      if (out_valid && out_ready) begin
        checks++;
        if (sb_q.size() == 0) begin
          fails++;
          $display("FAIL R7 unexpected pixel: got %h expected none", prev_bus);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if ({out_r, out_g, out_b, out_hsync, out_vsync} != {e.r, e.g, e.b, e.hs, e.vs}) begin
            fails++;
            $display("FAIL %s: got r=%0d g=%0d b=%0d hs=%0b vs=%0b expected r=%0d g=%0d b=%0d hs=%0b vs=%0b",
                     e.tag, out_r, out_g, out_b, out_hsync, out_vsync,
                     e.r, e.g, e.b, e.hs, e.vs);
          end
          if (lat_mode) begin
            checks++;
            if (cyc - e.cyc != 3) begin
              fails++;
              $display("FAIL R7 latency: got %0d expected 3", cyc - e.cyc);
            end
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 in reset: got valid=%0b ready=%0b expected 0 1", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 after reset: got valid=%0b ready=%0b expected 0 1", out_valid, in_ready);
    end

    // Phase 1: ready held high, isolated and back-to-back samples
    lat_mode = 1'b1;
    bp_mode  = 1'b0;
    send(0,   128, 128, 0, 0, "R4");
    send(100, 128, 128, 0, 0, "R4");
    send(255, 128, 128, 0, 0, "R4");
    idle(4);
    send(120, 128, 200, 0, 0, "R1");
    send(120, 90,  60,  0, 0, "R2");
    send(120, 200, 128, 0, 0, "R3");
    send(80,  30,  220, 1, 0, "R1 R2 R8");
    send(200, 170, 40,  0, 1, "R2 R3 R8");
    send(255, 128, 255, 1, 1, "R5");
    send(255, 255, 128, 0, 0, "R5");
    send(255, 0,   0,   0, 0, "R5");
    send(0,   128, 0,   1, 0, "R6");
    send(0,   0,   128, 0, 1, "R6");
    send(0,   255, 255, 0, 0, "R6");
    idle(2);
    send(16,  64,  192, 1, 0, "R8");
    idle(1);
    send(240, 192, 64,  0, 1, "R8");
    idle(6);

    // Phase 2: irregular back-pressure with a varied stream
    lat_mode = 1'b0;
    bp_mode  = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send(int'(lfsr[7:0]) ^ (i * 37 & 255), (i * 53 + 11) & 255, (i * 97 + 5) & 255,
           1'((i % 7) == 0), 1'((i % 31) == 0), "R1 R2 R3 R8 R9");
      if ((i % 13) == 0) idle(2);
    end
    wait (sb_q.size() == 0);
    idle(8);
    finish_run();
  end
endmodule